// File: doc/BRIEF.md
# Dual-Plane Pixel Source Selector

This block turns three parallel per-pixel planes into one stream of 32-bit display pixels. Each incoming beat carries an 8-bit palette index, a 32-bit direct-colour word and a 32-bit control word, with all three words taken in big-endian memory order. The most significant byte of the control word is a tag. One tag value selects the direct-colour bytes for the pixel. Any other value selects the palette entry named by the index. So a frame can mix true-colour regions and indexed regions down to single-pixel granularity.

Input and output use valid/ready handshakes. The palette sits outside the block and is reached through a synchronous read port. The block holds one pixel in flight. While the output is stalled it keeps re-reading the same palette entry, so nothing is lost or repeated. A configuration bit chooses the channel order of the packed output word.

Top module: `plane_pixel_merge`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0 and `in_ready` is 1.
- R2: When `in_ctrl[31:24]` equals 8'h03, the pixel colour comes from the direct word: red = `in_direct[7:0]`, green = `in_direct[15:8]`, blue = `in_direct[23:16]`. `in_direct[31:24]` has no effect on the output.
- R3: When `in_ctrl[31:24]` is any value other than 8'h03, the pixel colour is the palette entry at `in_index`. The palette returns {red[23:16], green[15:8], blue[7:0]} on `pal_rd_data` one cycle after an enabled read of `pal_rd_addr`.
- R4: `in_ctrl[23:0]` has no effect on the output.
- R5: With `cfg_bgr` = 0 the output packs red in bits 23:16, green in 15:8 and blue in 7:0. With `cfg_bgr` = 1 it packs blue in 23:16, green in 15:8 and red in 7:0. The bit acts on the pixel currently presented.
- R6: Bits 31:24 of `out_pixel` are always zero.
- R7: A pixel accepted at a clock edge (`in_valid` and `in_ready` both high) is presented with `out_valid` high right after that edge.
- R8: While `out_valid` is high and `out_ready` is low, the presented pixel is held unchanged. Every accepted pixel leaves exactly once, in acceptance order.
- R9: `in_ready` equals `!out_valid || out_ready`, so an unstalled stream moves one pixel per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bgr | input | 1 | Output channel order: 0 red-high, 1 blue-high |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_index | input | 8 | Palette index of the pixel |
| in_direct | input | 32 | Direct-colour word, big-endian |
| in_ctrl | input | 32 | Control word; top byte is the source tag |
| pal_rd_en | output | 1 | Palette read enable |
| pal_rd_addr | output | 8 | Palette read address |
| pal_rd_data | input | 24 | Palette entry, returned one cycle after the read |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_pixel | output | 32 | Packed output pixel |

## Verification
A wrong source-select flag or a stale stored index shows at the ports in the same cycle the pixel is presented: the output colour differs from both the palette entry and the direct bytes the bench expects. A valid flag that is dropped or set twice shows as a missing or doubled pixel in the stalled stream test, where each output is compared in order against the accepted inputs. A palette address that drifts during a stall changes the held pixel in the very next cycle, and the hold check catches that.

// File: rtl/pxm_pkg.sv
package pxm_pkg;

  localparam int CH_W   = 8;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  // Direct word in memory order: pad byte, blue, green, red (MSB to LSB).
  function automatic rgb_t direct_to_rgb(input logic [WORD_W-1:0] w);
    rgb_t c;
    c.b = w[3*CH_W-1:2*CH_W];
    c.g = w[2*CH_W-1:CH_W];
    c.r = w[CH_W-1:0];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] pack_pixel(input rgb_t c, input logic bgr);
    if (bgr) return {{(WORD_W-3*CH_W){1'b0}}, c.b, c.g, c.r};
    else     return {{(WORD_W-3*CH_W){1'b0}}, c.r, c.g, c.b};
  endfunction

endpackage

// File: rtl/pxm_tag_decode.sv
module pxm_tag_decode #(
  parameter int          WORD_W     = 32,
  parameter int          TAG_W      = 8,
  parameter logic [7:0]  TAG_DIRECT = 8'h03
) (
  input  logic [WORD_W-1:0] ctrl_word,
  output logic              is_direct
);
  localparam int TAG_LSB = WORD_W - TAG_W;

  logic [TAG_W-1:0] tag;
  logic             unused_low;

  assign tag        = ctrl_word[WORD_W-1:TAG_LSB];
  assign unused_low = ^ctrl_word[TAG_LSB-1:0];
  assign is_direct  = (tag == TAG_DIRECT[TAG_W-1:0]);
endmodule

// File: rtl/pxm_stage.sv
module pxm_stage
  import pxm_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             drain,
  input  logic [IDX_W-1:0] d_index,
  input  logic             d_direct,
  input  rgb_t             d_rgb,
  output logic             q_valid,
  output logic [IDX_W-1:0] q_index,
  output logic             q_direct,
  output rgb_t             q_rgb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_index  <= '0;
      q_direct <= 1'b0;
      q_rgb    <= '0;
    end else begin
      if (load) begin
        q_valid  <= 1'b1;
        q_index  <= d_index;
        q_direct <= d_direct;
        q_rgb    <= d_rgb;
      end else if (drain) begin
        q_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pxm_packer.sv
module pxm_packer
  import pxm_pkg::*;
(
  input  logic              sel_direct,
  input  rgb_t              direct_rgb,
  input  rgb_t              pal_rgb,
  input  logic              bgr,
  output logic [WORD_W-1:0] pixel
);
  rgb_t chosen;

  always_comb begin
    chosen = sel_direct ? direct_rgb : pal_rgb;
    pixel  = pack_pixel(chosen, bgr);
  end
endmodule

// File: rtl/plane_pixel_merge.sv
module plane_pixel_merge
  import pxm_pkg::*;
#(
  parameter int         IDX_W      = 8,
  parameter logic [7:0] TAG_DIRECT = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bgr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_index,
  input  logic [31:0]       in_direct,
  input  logic [31:0]       in_ctrl,
  output logic              pal_rd_en,
  output logic [IDX_W-1:0]  pal_rd_addr,
  input  logic [23:0]       pal_rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_pixel
);
  // Named internal events for the checker
  logic pix_load;
  logic pix_drain;
  logic tag_direct;

  logic             stg_valid;
  logic [IDX_W-1:0] stg_index;
  logic             stg_direct;
  rgb_t             stg_rgb;

  pxm_tag_decode #(
    .WORD_W    (WORD_W),
    .TAG_W     (CH_W),
    .TAG_DIRECT(TAG_DIRECT)
  ) u_tag (
    .ctrl_word(in_ctrl),
    .is_direct(tag_direct)
  );

  assign in_ready  = !stg_valid || out_ready;
  assign pix_load  = in_valid && in_ready;
  assign pix_drain = stg_valid && out_ready;

  pxm_stage #(.IDX_W(IDX_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (pix_load),
    .drain   (pix_drain),
    .d_index (in_index),
    .d_direct(tag_direct),
    .d_rgb   (direct_to_rgb(in_direct)),
    .q_valid (stg_valid),
    .q_index (stg_index),
    .q_direct(stg_direct),
    .q_rgb   (stg_rgb)
  );

  // Re-read the held index while stalled so the palette data stays aligned
  assign pal_rd_en   = pix_load || stg_valid;
  assign pal_rd_addr = pix_load ? in_index : stg_index;

  pxm_packer u_pack (
    .sel_direct(stg_direct),
    .direct_rgb(stg_rgb),
    .pal_rgb   (rgb_t'(pal_rd_data)),
    .bgr       (cfg_bgr),
    .pixel     (out_pixel)
  );

  assign out_valid = stg_valid;
endmodule

// File: rtl/plane_pixel_merge_chk.sv
module plane_pixel_merge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_bgr,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_pixel,
  input logic        pal_rd_en,
  input logic        pix_load,
  input logic        pix_drain
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_top_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_pixel[31:24] == 8'h00);

  p_present_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_load |=> out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && ((cfg_bgr != $past(cfg_bgr)) || $stable(out_pixel)));

  p_leave_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_drain && !pix_load) |=> !out_valid);

  p_reread_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> (pal_rd_en && !pix_load));

  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));
endmodule

bind plane_pixel_merge plane_pixel_merge_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_bgr  (cfg_bgr),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_pixel(out_pixel),
  .pal_rd_en(pal_rd_en),
  .pix_load (pix_load),
  .pix_drain(pix_drain)
);

// File: tb/test_plane_pixel_merge.sv
module test_plane_pixel_merge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_bgr = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_index = '0;
  logic [31:0] in_direct = '0;
  logic [31:0] in_ctrl = '0;
  logic        pal_rd_en;
  logic [7:0]  pal_rd_addr;
  logic [23:0] pal_rd_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_pixel;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  plane_pixel_merge i_plane_pixel_merge (
    .clk(clk), .rst_n(rst_n), .cfg_bgr(cfg_bgr),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_index(in_index), .in_direct(in_direct), .in_ctrl(in_ctrl),
    .pal_rd_en(pal_rd_en), .pal_rd_addr(pal_rd_addr), .pal_rd_data(pal_rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel)
  );

  // Palette contents, red in 23:16, green 15:8, blue 7:0
  function automatic logic [23:0] pal_fn(input logic [7:0] i);
    return {i ^ 8'hA5, i + 8'h3C, ~i};
  endfunction

  always @(posedge clk) if (pal_rd_en) pal_rd_data <= pal_fn(pal_rd_addr);

  function automatic logic [31:0] model(input logic [7:0] idx, input logic [31:0] dir,
                                        input logic [31:0] ctl, input logic bgr);
    logic [7:0] r, g, b;
    if (ctl[31:24] == 8'h03) begin
      r = dir[7:0]; g = dir[15:8]; b = dir[23:16];
    end else begin
      {r, g, b} = pal_fn(idx);
    end
    return bgr ? {8'h00, b, g, r} : {8'h00, r, g, b};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // {bgr, index, direct, ctrl}
  localparam logic [72:0] VEC [8] = '{
    {1'b0, 8'h12, 32'hFF0A0B0C, 32'h03000000},
    {1'b1, 8'h34, 32'h11223344, 32'h03FFFFFF},
    {1'b0, 8'h56, 32'hDEADBEEF, 32'h02000000},
    {1'b1, 8'h00, 32'h01020304, 32'h00000000},
    {1'b0, 8'hFF, 32'hCAFEF00D, 32'h04123456},
    {1'b1, 8'h80, 32'h00000000, 32'h83000000},
    {1'b0, 8'h7F, 32'h80FFFFFF, 32'h30000003},
    {1'b0, 8'h03, 32'h00A0B0C0, 32'h03ABCDEF}
  };

  localparam int N_STREAM = 24;

  function automatic logic [7:0]  s_idx(input int k); return 8'(k * 7); endfunction
  function automatic logic [31:0] s_dir(input int k); return {8'hEE, 8'(k * 3), 8'(k * 5), 8'(k * 11)}; endfunction
  function automatic logic [31:0] s_ctl(input int k); return {((k % 3) == 0) ? 8'h03 : 8'(k), 24'(k * 13)}; endfunction

  initial begin
    #(20 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1 / R9: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 out_valid in reset", 32'(out_valid), 32'd0);
    check("R1 in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", 32'(out_valid), 32'd0);
    check("R9 in_ready idle", 32'(in_ready), 32'd1);

    // Vector table: R2, R3, R4, R5, R6, R7
    out_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      logic [72:0] v;
      v = VEC[i];
      @(negedge clk);
      cfg_bgr = v[72]; in_index = v[71:64]; in_direct = v[63:32]; in_ctrl = v[31:0];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R7 out_valid after accept", 32'(out_valid), 32'd1);
      check((v[31:24] == 8'h03) ? "R2 R4 R5 R6 direct pixel" : "R3 R4 R5 R6 palette pixel",
            out_pixel, model(v[71:64], v[63:32], v[31:0], v[72]));
    end

    // R8 / R9 / R5: stall holds the pixel, config bit re-packs it
    @(negedge clk);
    out_ready = 1'b0; cfg_bgr = 1'b0;
    in_index = 8'h9C; in_direct = 32'h55667788; in_ctrl = 32'h01000000; in_valid = 1'b1;
    @(negedge clk);
    in_index = 8'h21; in_direct = 32'h00123456; in_ctrl = 32'h03000000;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R8 held pixel during stall", out_pixel, model(8'h9C, 32'h55667788, 32'h01000000, 1'b0));
      check("R9 in_ready low during stall", 32'(in_ready), 32'd0);
    end
    cfg_bgr = 1'b1;
    #1;
    check("R5 bgr applied to held pixel", out_pixel, model(8'h9C, 32'h55667788, 32'h01000000, 1'b1));
    cfg_bgr = 1'b0;
    out_ready = 1'b1;
    #1;
    check("R9 in_ready with out_ready", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next pixel after stall", out_pixel, model(8'h21, 32'h00123456, 32'h03000000, 1'b0));
    @(negedge clk);
    check("R8 drained once", 32'(out_valid), 32'd0);

    // R8: streamed pixels with gaps and stalls, order and count
    begin
      int wr = 0;
      int rd = 0;
      cfg_bgr = 1'b1;
      for (int cyc = 0; cyc < 400 && rd < N_STREAM; cyc++) begin
        @(negedge clk);
        out_ready = ((cyc % 4) != 1) && ((cyc % 9) != 4);
        if (wr < N_STREAM && (cyc % 5) != 2) begin
          in_valid = 1'b1; in_index = s_idx(wr); in_direct = s_dir(wr); in_ctrl = s_ctl(wr);
        end else begin
          in_valid = 1'b0;
        end
        #1;
        if (out_valid && out_ready) begin
          check("R8 stream order", out_pixel, model(s_idx(rd), s_dir(rd), s_ctl(rd), 1'b1));
          rd++;
        end
        if (in_valid && in_ready) wr++;
      end
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1;
      check("R8 stream count", 32'(rd), 32'(N_STREAM));
      @(negedge clk);
      check("R8 no extra pixel", 32'(out_valid), 32'd0);
    end

    // R1: reset while a pixel is held
    out_ready = 1'b0;
    in_index = 8'h44; in_ctrl = 32'h00000000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 reset clears held pixel", 32'(out_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    check("R1 idle after second reset", 32'(out_valid), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule